// File: doc/BRIEF.md
# Splittable Performance Counter Bank

This block holds four physical event counters that software reaches through a small register port. Each physical counter can run as one 32-bit count or be split into two separate 16-bit counts, so the bank offers eight logical counters. Every logical counter has its own control register, which chooses one of eight event inputs and gates counting with a local enable bit. A global control register holds the monitor enable and one size bit per physical counter.

Software never writes a running count directly. A counter write lands in a holding latch for that physical counter. The latch is copied into the live counter when the global control register is written with its enable bit set. A pending mask shows which latches hold values newer than their counters. Control registers are write-only from the software side, so the block keeps readable shadow copies of all of them.

A two-state monitor machine is the core of the block. In state `MON_OFF` the counters hold. In state `MON_RUN` they count. The transition `OFF_TO_RUN` happens on a global write with the enable bit set. `RUN_TO_OFF` happens on a global write with it clear. `RUN_RELOAD` is a global write with the enable bit set while already running: the state stays `MON_RUN` and the latches are committed again.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, latch, pending bit and control register is zero. The monitor is off and all physical counters are in 32-bit mode.
- R2: The 32-bit register word travels in bits 63:32 of `wdata` and `rdata`. Bits 31:0 of `wdata` are ignored and bits 31:0 of `rdata` are zero. A read asserts `rdata_valid` one cycle after `rd_en`.
- R3: Address map: 0..7 logical counters, 8..15 counter controls, 16 global control, 17 pending mask. A counter write goes to the latch of its physical counter, not to the live count. A counter write while the monitor is off sets pending bit p (bit p of the mask at address 17). A counter read returns the latch when its pending bit is set, and the live count otherwise.
- R4: A global write with bit 31 set loads all four counters from their latches and clears the pending mask. This also happens when the monitor is already on.
- R5: While the monitor is on, a counter advances by one on each clock edge at which its control has bit 3 set and the event input chosen by bits 2:0 is high. While the monitor is off, counters hold.
- R6: In 32-bit mode the control of logical counter p drives physical counter p, and the count wraps from 0xFFFFFFFF to 0. Logical counters 4..7 in 32-bit mode read and write all of physical counter p-4.
- R7: Bit p (p = 0..3) of the global control set selects 16-bit mode. Logical p is then the upper half and logical p+4 the lower half, each read zero-extended, each counting under its own control, and a lower-half wrap does not carry into the upper half.
- R8: A 16-bit counter write replaces one half of the latch. The other half is taken from the counter's current read value.
- R9: Counter-control registers read back the full word last written. The global control reads back its written bits 30:0, with bit 31 showing the monitor state.
- R10: A counter write while the monitor is on leaves the pending bit clear and the live count unchanged until the next commit.
- R11: The monitor machine moves `MON_OFF` to `MON_RUN` on a global write with bit 31 set. It moves `MON_RUN` to `MON_OFF` on a global write with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 64 | Write bus word, data in bits 63:32 |
| events | input | 8 | Event inputs selectable by the controls |
| rdata | output | 64 | Read bus word, data in bits 63:32 |
| rdata_valid | output | 1 | High the cycle after a read strobe |

## Verification
- **Writes:** a register write, a commit and a state change all take effect at the clock edge that samples the strobe.
- **Counting:** an event held high across N edges adds exactly N to the count, so the bench drives events for whole cycles between falling edges.
- **Reads:** read data is registered and appears one cycle after `rd_en`. It reflects the state before that sampling edge.
- **Scoreboard:** the bench pushes each expected word into a queue when it issues a read. A falling-edge monitor pops the queue whenever `rdata_valid` is high, so every comparison lands exactly in the cycle the result is due.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int PCB_WORD_W = 32;
    localparam int PCB_EN_BIT = 31;

    typedef enum logic [0:0] {
        MON_OFF = 1'b0,
        MON_RUN = 1'b1
    } mon_state_e;
endpackage

// File: rtl/pcb_monitor_ctrl.sv
module pcb_monitor_ctrl
    import pcb_pkg::*;
#(
    parameter int NUM_PHYS = 4,
    parameter int NUM_LOG  = 2 * NUM_PHYS,
    parameter int LOG_W    = $clog2(NUM_LOG)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 glb_wr,
    input  logic                                 ctl_wr,
    input  logic [LOG_W-1:0]                     ctl_idx,
    input  logic [PCB_WORD_W-1:0]                wr_word,
    output logic                                 run,
    output logic                                 commit,
    output logic [NUM_PHYS-1:0]                  size16,
    output logic [PCB_WORD_W-1:0]                glb_rd,
    output logic [NUM_LOG-1:0][PCB_WORD_W-1:0]   ctl_q
);
    mon_state_e state_q, state_d;
    logic [PCB_EN_BIT-1:0] glb_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MON_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OFF: if (glb_wr && wr_word[PCB_EN_BIT])  state_d = MON_RUN;
            MON_RUN: if (glb_wr && !wr_word[PCB_EN_BIT]) state_d = MON_OFF;
            default: state_d = MON_OFF;
        endcase
    end

    // outputs
    always_comb begin
        run    = 1'b0;
        commit = glb_wr && wr_word[PCB_EN_BIT];
        unique case (state_q)
            MON_OFF: run = 1'b0;
            MON_RUN: run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    // shadow copies of the write-only controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= '0;
            ctl_q <= '0;
        end else begin
            if (glb_wr) glb_q <= wr_word[PCB_EN_BIT-1:0];
            if (ctl_wr) ctl_q[ctl_idx] <= wr_word;
        end
    end

    assign size16 = glb_q[NUM_PHYS-1:0];
    assign glb_rd = {run, glb_q};

    assert_enable_enters_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_wr && wr_word[PCB_EN_BIT]) |=> (state_q == MON_RUN));
    assert_disable_enters_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_wr && !wr_word[PCB_EN_BIT]) |=> (state_q == MON_OFF));
    assert_shadow_keeps_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_q[$past(ctl_idx)] == $past(wr_word)));
endmodule

// File: rtl/pcb_phys_counter.sv
module pcb_phys_counter
    import pcb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  commit,
    input  logic                  size16,
    input  logic                  wr_full,
    input  logic                  wr_upper,
    input  logic                  wr_lower,
    input  logic [PCB_WORD_W-1:0] wr_val,
    input  logic                  inc_hi,
    input  logic                  inc_lo,
    output logic [PCB_WORD_W-1:0] rd_val,
    output logic                  pending
);
    localparam int W      = PCB_WORD_W;
    localparam int HALF_W = W / 2;

    logic [W-1:0] cnt_q, cnt_d, latch_q, latch_d;
    logic         pend_q, pend_d, wr_any;

    assign wr_any  = wr_full || wr_upper || wr_lower;
    assign rd_val  = pend_q ? latch_q : cnt_q;
    assign pending = pend_q;

    always_comb begin
        latch_d = latch_q;
        if (wr_full)
            latch_d = wr_val;
        else if (wr_upper)
            latch_d = {wr_val[HALF_W-1:0], rd_val[HALF_W-1:0]};
        else if (wr_lower)
            latch_d = {rd_val[W-1:HALF_W], wr_val[HALF_W-1:0]};
    end

    always_comb begin
        cnt_d = cnt_q;
        if (commit)
            cnt_d = latch_q;
        else if (run) begin
            if (size16) begin
                cnt_d[W-1:HALF_W]  = cnt_q[W-1:HALF_W] + HALF_W'(inc_hi);
                cnt_d[HALF_W-1:0]  = cnt_q[HALF_W-1:0] + HALF_W'(inc_lo);
            end else begin
                cnt_d = cnt_q + W'(inc_hi);
            end
        end
    end

    always_comb begin
        pend_d = pend_q;
        if (commit)              pend_d = 1'b0;
        else if (wr_any && !run) pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            latch_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            latch_q <= latch_d;
            pend_q  <= pend_d;
        end
    end

    assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pend_q);
    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !commit) |=> $stable(cnt_q));
    assert_half_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && size16 && !commit && !inc_hi) |=> (cnt_q[W-1:HALF_W] == $past(cnt_q[W-1:HALF_W])));
    assert_run_write_not_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_any && !pend_q && !commit) |=> !pend_q);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_PHYS   = 4,
    parameter int NUM_EVENTS = 8,
    parameter int ADDR_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2*PCB_WORD_W-1:0] wdata,
    input  logic [NUM_EVENTS-1:0]   events,
    output logic [2*PCB_WORD_W-1:0] rdata,
    output logic                    rdata_valid
);
    localparam int NUM_LOG = 2 * NUM_PHYS;
    localparam int LOG_W   = $clog2(NUM_LOG);
    localparam int PH_W    = $clog2(NUM_PHYS);
    localparam int SEL_W   = $clog2(NUM_EVENTS);
    localparam int HALF_W  = PCB_WORD_W / 2;
    localparam logic [ADDR_W-1:0] A_HI_END = ADDR_W'(NUM_PHYS);
    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(NUM_LOG);
    localparam logic [ADDR_W-1:0] A_GLB    = ADDR_W'(2 * NUM_LOG);
    localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(2 * NUM_LOG + 1);

    logic [PCB_WORD_W-1:0]               wr_word, rd_word, glb_rd, pv;
    logic                                run, commit, glb_wr, ctl_wr;
    logic [NUM_PHYS-1:0]                 size16, pend;
    logic [NUM_LOG-1:0][PCB_WORD_W-1:0]  ctl_q;
    logic [NUM_PHYS-1:0][PCB_WORD_W-1:0] rd_val;
    logic [PH_W-1:0]                     pidx;
    logic                                unused_low;

    assign wr_word    = wdata[2*PCB_WORD_W-1:PCB_WORD_W];
    assign unused_low = ^wdata[PCB_WORD_W-1:0];
    assign glb_wr     = wr_en && (addr == A_GLB);
    assign ctl_wr     = wr_en && (addr >= A_CTL) && (addr < A_GLB);

    pcb_monitor_ctrl #(
        .NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG), .LOG_W(LOG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .glb_wr(glb_wr), .ctl_wr(ctl_wr),
        .ctl_idx(addr[LOG_W-1:0]), .wr_word(wr_word), .run(run),
        .commit(commit), .size16(size16), .glb_rd(glb_rd), .ctl_q(ctl_q)
    );

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(p);
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(p + NUM_PHYS);
        logic hit_hi, hit_lo, inc_hi, inc_lo;

        assign hit_hi = wr_en && (addr == A_HI);
        assign hit_lo = wr_en && (addr == A_LO);
        assign inc_hi = run && ctl_q[p][SEL_W] && events[ctl_q[p][SEL_W-1:0]];
        assign inc_lo = run && ctl_q[p+NUM_PHYS][SEL_W]
                            && events[ctl_q[p+NUM_PHYS][SEL_W-1:0]];

        pcb_phys_counter u_cnt (
            .clk(clk), .rst_n(rst_n), .run(run), .commit(commit),
            .size16(size16[p]),
            .wr_full((hit_hi || hit_lo) && !size16[p]),
            .wr_upper(hit_hi && size16[p]),
            .wr_lower(hit_lo && size16[p]),
            .wr_val(wr_word), .inc_hi(inc_hi), .inc_lo(inc_lo),
            .rd_val(rd_val[p]), .pending(pend[p])
        );
    end

    // read multiplexer
    always_comb begin
        rd_word = '0;
        pidx    = addr[PH_W-1:0];
        pv      = rd_val[pidx];
        if (addr < A_CTL) begin
            if (!size16[pidx])
                rd_word = pv;
            else if (addr < A_HI_END)
                rd_word = {{HALF_W{1'b0}}, pv[PCB_WORD_W-1:HALF_W]};
            else
                rd_word = {{HALF_W{1'b0}}, pv[HALF_W-1:0]};
        end else if (addr < A_GLB) begin
            rd_word = ctl_q[addr[LOG_W-1:0]];
        end else if (addr == A_GLB) begin
            rd_word = glb_rd;
        end else if (addr == A_PEND) begin
            rd_word = PCB_WORD_W'(pend);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= rd_en;
            if (rd_en) rdata <= {rd_word, {PCB_WORD_W{1'b0}}};
        end
    end

    assert_read_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rdata_valid);
    assert_commit_empties_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (pend == '0));
endmodule

// File: tb/perf_counter_bank_bench.sv
module perf_counter_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [7:0]  events = '0;
    logic [63:0] rdata;
    logic        rdata_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    perf_counter_bank u_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .events(events), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [31:0] low);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = {d, low};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: push expected word, then issue the read
    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] mask, input int n);
        @(negedge clk);
        events = mask;
        repeat (n) @(negedge clk);
        events = '0;
    endtask

    // monitor: compare each result in the cycle it is due
    always @(negedge clk) begin
        if (rst_n && rdata_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected read data: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== {e, 32'h0}) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, {e, 32'h0});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd0,  32'h0, "R1 counter 0 after reset");
        rd(5'd16, 32'h0, "R1 global after reset");
        rd(5'd17, 32'h0, "R1 pending after reset");
        rd(5'd11, 32'h0, "R1 control 3 after reset");

        // R3 latch write while off, R2 low half ignored
        wr(5'd0, 32'h12345678, 32'hDEADBEEF);
        rd(5'd17, 32'h1, "R3 pending bit 0 set");
        rd(5'd0, 32'h12345678, "R3 read returns latch");
        rd(5'd1, 32'h0, "R3 other counter untouched");

        // R9 control shadow: enable + select event 2
        wr(5'd8, 32'h0000000A, 32'hFFFFFFFF);
        rd(5'd8, 32'h0000000A, "R9 control 0 readback");

        // R4/R11 enable commits
        wr(5'd16, 32'h80000000, 32'h0);
        rd(5'd17, 32'h0, "R4 pending cleared by enable");
        rd(5'd16, 32'h80000000, "R11 global shows run");
        pulse(8'h04, 5);
        rd(5'd0, 32'h1234567D, "R5 five events counted");

        // R10 write while running stays in latch
        wr(5'd0, 32'hFFFFFFFE, 32'h0);
        rd(5'd17, 32'h0, "R10 no pending while running");
        rd(5'd0, 32'h1234567D, "R10 live count unchanged");
        wr(5'd16, 32'h80000000, 32'h0);
        rd(5'd0, 32'hFFFFFFFE, "R4 recommit while running");
        pulse(8'h04, 3);
        rd(5'd0, 32'h00000001, "R6 32-bit wrap");

        // R5 hold when off, R11 back to off
        wr(5'd16, 32'h0, 32'h0);
        pulse(8'h04, 4);
        rd(5'd0, 32'h00000001, "R5 hold while off");
        rd(5'd16, 32'h0, "R11 global shows off");

        // R7/R8 split physical counter 1
        wr(5'd16, 32'h00000002, 32'h0);
        wr(5'd9,  32'h00000008, 32'h0);
        wr(5'd13, 32'h00000009, 32'h0);
        wr(5'd1,  32'h0000AAAA, 32'h0);
        wr(5'd5,  32'h0000FFFE, 32'h0);
        rd(5'd17, 32'h2, "R3 pending bit 1 set");
        rd(5'd1, 32'h0000AAAA, "R8 upper half written");
        rd(5'd5, 32'h0000FFFE, "R8 lower half merged");
        rd(5'd0, 32'h00000001, "R3 live value when not pending");

        wr(5'd16, 32'h80000002, 32'h0);
        pulse(8'h02, 3);
        rd(5'd5, 32'h00000001, "R7 lower half wraps");
        rd(5'd1, 32'h0000AAAA, "R7 no carry into upper");
        pulse(8'h01, 2);
        rd(5'd1, 32'h0000AAAC, "R7 upper counts alone");
        rd(5'd5, 32'h00000001, "R7 lower unaffected");
        rd(5'd4, 32'hFFFFFFFE, "R6 logical 4 full in 32-bit mode");
        rd(5'd0, 32'hFFFFFFFE, "R4 every latch committed");

        // R2 low half of write ignored
        wr(5'd10, 32'h00000005, 32'hFFFFFFFF);
        rd(5'd10, 32'h00000005, "R2 low write half ignored");
        rd(5'd16, 32'h80000002, "R9 global readback");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing reads: actual %0d left expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule